// File: doc/BRIEF.md
# Transceiver Power-Down and Reset Sequencer

This block sits on the module side of a pluggable transceiver. It controls the single host pin that carries both a power-down level and a reset edge. While the pin is high, the module is held in low-power mode. When the pin falls after a high period that lasted long enough, a complete reset starts, equivalent to a power cycle. The same timed initialization also runs after power-on.

The block keeps a small bank of sticky interrupt flags. A host clear-on-read strobe clears them, and an active-low interrupt output is pulled while any flag is set. The not-ready status output is the OR of three fault inputs: transmit lock loss, laser fault and receive lock loss. The not-ready and loss-of-signal outputs are held at a defined value until the outputs are trustworthy, which excludes initialization and power-down. The outputs become live before the reset-complete interrupt is raised.

Top module: `xcvr_pdrst_seq`

## Requirements
- R1: `lowpwr_o` follows the level of `pdrst_i` through a two-stage synchronizer and one output register, so it changes on the third clock edge after the pin changes. It is 1 during `rst_ni` low.
- R2: A falling edge on `pdrst_i` after the pin was high for at least `MIN_PD_CYCLES` synchronized cycles starts a complete reset. A shorter high pulse starts no reset and sets no flag.
- R3: After power-on reset release, or after an accepted falling edge, the reset-complete interrupt asserts no earlier than `INIT_CYCLES` and no later than `INIT_CYCLES`+4 clock cycles later.
- R4: When live, `not_ready_o` is the OR of `tx_lol_i`, `laser_fault_i` and `rx_lol_i`, and `los_o` follows `los_i`, each through one register.
- R5: During initialization and while the synchronized pin is high, `not_ready_o` and `los_o` are both driven to 1.
- R6: When not in power-down, `not_ready_o` and `los_o` carry their live values at least one cycle before `int_no` falls for reset completion.
- R7: `flags_o` holds three sticky flags. Bit 0 is reset complete, bit 1 is a rise of not-ready, and bit 2 is a rise of loss-of-signal. `int_no` is 0 exactly when some flag is set.
- R8: During power-down and during initialization, only the reset-complete flag can be set. Fault and loss inputs raise no flag.
- R9: A cycle with `flag_rd_i` high clears the flags shown in that cycle, and `int_no` releases after that edge. A flag event in the same cycle as the read is kept.
- R10: A complete reset clears all pending flags when it starts.
- R11: If `rst_ni` is released with the pin high, the block stays in low-power mode and completes a reset with only the reset-complete flag set. The later release of the pin causes a second reset and a second reset-complete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cycle clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| pdrst_i | input | 1 | Host power-down level / reset-edge pin (asynchronous) |
| tx_lol_i | input | 1 | Transmit clock recovery loss of lock |
| laser_fault_i | input | 1 | Laser fault |
| rx_lol_i | input | 1 | Receive clock recovery loss of lock |
| los_i | input | 1 | Raw receive loss of signal |
| flag_rd_i | input | 1 | Clear-on-read strobe for the flag bank |
| lowpwr_o | output | 1 | Low-power mode enable |
| int_no | output | 1 | Active-low interrupt |
| not_ready_o | output | 1 | Gated module not-ready status |
| los_o | output | 1 | Gated loss-of-signal status |
| flags_o | output | 3 | Flag readback: bit0 reset complete, bit1 not-ready rise, bit2 LOS rise |

## Verification
The bench targets several corner cases, and a faulty design shows each one as follows.
- A short power-down glitch must not restart the module. A design that ignores the minimum width would raise a fresh reset-complete interrupt.
- Power-on with the pin already high must stay in low-power mode and still report one completion, then report a second completion after release. A design that merges the two resets would miss the second flag.
- Faults toggled during power-down must not set flags. A design that gates only the outputs, and not the event logic, would pull the interrupt spuriously.
- A read that coincides with a new event must keep the new flag. A design that clears the whole bank would lose it.
- The cycle before the completion interrupt must show live status. A design that opens the gate together with the flag would show the forced value.

// File: rtl/xcvr_pdrst_pkg.sv
package xcvr_pdrst_pkg;
  localparam int FLAG_N       = 3;
  localparam int FLAG_RSTDONE = 0;
  localparam int FLAG_NR      = 1;
  localparam int FLAG_LOS     = 2;

  typedef enum logic [1:0] {
    SEQ_INIT   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_RUN    = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pdrst_pin_cond.sv
module pdrst_pin_cond #(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_PD_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pd_s_o,
  output logic lowpwr_o,
  output logic restart_o
);
  localparam int HI_W = $clog2(MIN_PD_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HI_W-1:0]        hi_q;
  logic                   lowpwr_q;
  logic                   pd_s;

  // pin is pulled high when undriven: reset the chain to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign pd_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= '0;
      lowpwr_q <= 1'b1;
    end else begin
      lowpwr_q <= pd_s;
      if (!pd_s)                              hi_q <= '0;
      else if (hi_q != HI_W'(MIN_PD_CYCLES))  hi_q <= hi_q + 1'b1;
    end
  end

  assign pd_s_o    = pd_s;
  assign lowpwr_o  = lowpwr_q;
  assign restart_o = lowpwr_q && !pd_s && (hi_q >= HI_W'(MIN_PD_CYCLES));
endmodule

// File: rtl/init_seq_fsm.sv
module init_seq_fsm
  import xcvr_pdrst_pkg::*;
#(
  parameter int INIT_CYCLES = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  output seq_state_e state_o,
  output seq_state_e state_next_o,
  output logic       done_o
);
  localparam int CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_o  = 1'b0;
    if (restart_i) begin
      state_d = SEQ_INIT;
      cnt_d   = CNT_W'(INIT_CYCLES - 1);
    end else begin
      unique case (state_q)
        SEQ_INIT: begin
          if (cnt_q == '0) state_d = SEQ_SETTLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
        SEQ_SETTLE: begin
          state_d = SEQ_RUN;
          done_o  = 1'b1;
        end
        default: state_d = SEQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_INIT;
      cnt_q   <= CNT_W'(INIT_CYCLES - 1);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o      = state_q;
  assign state_next_o = state_d;
endmodule

// File: rtl/status_gate.sv
module status_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic live_i,
  input  logic ev_en_i,
  input  logic tx_lol_i,
  input  logic laser_fault_i,
  input  logic rx_lol_i,
  input  logic los_i,
  output logic nr_o,
  output logic los_o,
  output logic ev_nr_o,
  output logic ev_los_o
);
  logic nr_raw, nr_q, los_q;

  assign nr_raw = tx_lol_i | laser_fault_i | rx_lol_i;

  // forced value is 1: leaving a forced period can never look like a rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nr_q  <= 1'b1;
      los_q <= 1'b1;
    end else begin
      nr_q  <= live_i ? nr_raw : 1'b1;
      los_q <= live_i ? los_i  : 1'b1;
    end
  end

  assign ev_nr_o  = ev_en_i && nr_raw && !nr_q;
  assign ev_los_o = ev_en_i && los_i  && !los_q;
  assign nr_o     = nr_q;
  assign los_o    = los_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         rd_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o,
  output logic         int_no
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_q[i] <= 1'b0;
      else if (clr_i)  flag_q[i] <= 1'b0;
      else             flag_q[i] <= (flag_q[i] & ~rd_i) | set_i[i];
    end
  end

  assign flags_o = flag_q;
  assign int_no  = ~|flag_q;
endmodule

// File: rtl/xcvr_pdrst_seq.sv
module xcvr_pdrst_seq
  import xcvr_pdrst_pkg::*;
#(
  parameter int INIT_CYCLES   = 64,
  parameter int MIN_PD_CYCLES = 10,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pdrst_i,
  input  logic              tx_lol_i,
  input  logic              laser_fault_i,
  input  logic              rx_lol_i,
  input  logic              los_i,
  input  logic              flag_rd_i,
  output logic              lowpwr_o,
  output logic              int_no,
  output logic              not_ready_o,
  output logic              los_o,
  output logic [FLAG_N-1:0] flags_o
);
  logic              pd_s, restart, done;
  logic              live, ev_en, ev_nr, ev_los;
  seq_state_e        state_q, state_d;
  logic [FLAG_N-1:0] set_vec;

  pdrst_pin_cond #(
    .SYNC_STAGES  (SYNC_STAGES),
    .MIN_PD_CYCLES(MIN_PD_CYCLES)
  ) u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (pdrst_i),
    .pd_s_o   (pd_s),
    .lowpwr_o (lowpwr_o),
    .restart_o(restart)
  );

  init_seq_fsm #(
    .INIT_CYCLES(INIT_CYCLES)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .state_o     (state_q),
    .state_next_o(state_d),
    .done_o      (done)
  );

  // status opens on entry to settle, one cycle ahead of the done flag
  assign live  = (state_d != SEQ_INIT) && !pd_s;
  assign ev_en = (state_q == SEQ_RUN) && !pd_s && !restart;

  status_gate u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .live_i       (live),
    .ev_en_i      (ev_en),
    .tx_lol_i     (tx_lol_i),
    .laser_fault_i(laser_fault_i),
    .rx_lol_i     (rx_lol_i),
    .los_i        (los_i),
    .nr_o         (not_ready_o),
    .los_o        (los_o),
    .ev_nr_o      (ev_nr),
    .ev_los_o     (ev_los)
  );

  always_comb begin
    set_vec               = '0;
    set_vec[FLAG_RSTDONE] = done;
    set_vec[FLAG_NR]      = ev_nr;
    set_vec[FLAG_LOS]     = ev_los;
  end

  irq_flag_bank #(
    .N(FLAG_N)
  ) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .rd_i   (flag_rd_i),
    .set_i  (set_vec),
    .flags_o(flags_o),
    .int_no (int_no)
  );
endmodule

// File: rtl/xcvr_pdrst_seq_chk.sv
module xcvr_pdrst_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_lol_i,
  input logic       laser_fault_i,
  input logic       rx_lol_i,
  input logic       los_i,
  input logic       flag_rd_i,
  input logic       lowpwr_o,
  input logic       not_ready_o,
  input logic       los_o,
  input logic [2:0] flags_o
);
  AST_PD_STATUS_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_o |-> (not_ready_o && los_o)); // R5

  AST_PD_NO_EVENT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_o |-> (!$rose(flags_o[1]) && !$rose(flags_o[2]))); // R8

  AST_RSTDONE_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && flags_o[0]) |=> !flags_o[0]); // R9

  AST_NR_LOW_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !not_ready_o |-> $past(!(tx_lol_i || laser_fault_i || rx_lol_i))); // R4

  AST_LOS_LOW_NO_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !los_o |-> $past(!los_i)); // R4
endmodule

bind xcvr_pdrst_seq xcvr_pdrst_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_lol_i     (tx_lol_i),
  .laser_fault_i(laser_fault_i),
  .rx_lol_i     (rx_lol_i),
  .los_i        (los_i),
  .flag_rd_i    (flag_rd_i),
  .lowpwr_o     (lowpwr_o),
  .not_ready_o  (not_ready_o),
  .los_o        (los_o),
  .flags_o      (flags_o)
);

// File: tb/xcvr_pdrst_seq_tb.sv
`timescale 1ns/1ps
module xcvr_pdrst_seq_tb;
  localparam int INIT = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0, pdrst_i = 1'b0;
  logic tx_lol_i = 1'b0, laser_fault_i = 1'b0, rx_lol_i = 1'b0, los_i = 1'b0;
  logic flag_rd_i = 1'b0;
  logic lowpwr_o, int_no, not_ready_o, los_o;
  logic [2:0] flags_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  xcvr_pdrst_seq #(.INIT_CYCLES(INIT), .MIN_PD_CYCLES(10)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pdrst_i(pdrst_i),
    .tx_lol_i(tx_lol_i), .laser_fault_i(laser_fault_i), .rx_lol_i(rx_lol_i),
    .los_i(los_i), .flag_rd_i(flag_rd_i), .lowpwr_o(lowpwr_o), .int_no(int_no),
    .not_ready_o(not_ready_o), .los_o(los_o), .flags_o(flags_o));

  // {tx, laser, rx, los, exp_nr, exp_los}
  localparam logic [5:0] VEC [8] = '{
    6'b0000_00, 6'b1000_10, 6'b0100_10, 6'b0010_10,
    6'b0001_01, 6'b1111_11, 6'b0110_10, 6'b0000_00};

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_flags();
    flag_rd_i = 1'b1; tick(1); flag_rd_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic prev_nr;
    tick(3);
    // reset state
    chk(not_ready_o && los_o, "R5 reset forced", {not_ready_o, los_o}, 3);
    chk(int_no == 1 && flags_o == 0, "R7 reset flags", flags_o, 0);
    chk(lowpwr_o == 1, "R1 reset lowpwr", lowpwr_o, 1);

    // power-on, pin low: timing and live status before interrupt
    rst_ni = 1'b1; #1;
    cyc = 0; prev_nr = not_ready_o;
    while (int_no && cyc < INIT + 20) begin
      prev_nr = not_ready_o; tick(1); cyc++;
    end
    chk(cyc >= INIT && cyc <= INIT + 4, "R3 init length", cyc, INIT + 1);
    chk(prev_nr == 0, "R6 status live before interrupt", prev_nr, 0);
    chk(flags_o == 3'b001, "R7 reset-complete flag", flags_o, 1);
    chk(lowpwr_o == 0, "R1 lowpwr low", lowpwr_o, 0);
    read_flags();
    chk(flags_o == 0 && int_no == 1, "R9 read clears", flags_o, 0);

    // vector walk on fault combinations
    foreach (VEC[i]) begin
      {tx_lol_i, laser_fault_i, rx_lol_i, los_i} = VEC[i][5:2];
      tick(2);
      chk(not_ready_o == VEC[i][1], "R4 not-ready OR", not_ready_o, VEC[i][1]);
      chk(los_o == VEC[i][0], "R4 los follow", los_o, VEC[i][0]);
    end
    chk(flags_o == 3'b110, "R7 rise flags", flags_o, 6);
    read_flags();

    // read coinciding with a new event
    los_i = 1'b1; tick(2);
    chk(flags_o == 3'b100, "R7 los flag", flags_o, 4);
    flag_rd_i = 1'b1; tx_lol_i = 1'b1; tick(1); flag_rd_i = 1'b0;
    chk(flags_o == 3'b010, "R9 same-cycle event kept", flags_o, 2);
    tx_lol_i = 1'b0; los_i = 1'b0; tick(2); read_flags();
    chk(flags_o == 0 && int_no == 1, "R9 int released", flags_o, 0);

    // pending flag, then power-down
    los_i = 1'b1; tick(2); los_i = 1'b0; tick(2);
    pdrst_i = 1'b1; tick(3);
    chk(lowpwr_o == 1, "R1 lowpwr follows pin", lowpwr_o, 1);
    chk(not_ready_o && los_o, "R5 pd forced", {not_ready_o, los_o}, 3);
    rx_lol_i = 1'b1; los_i = 1'b1; tick(3); rx_lol_i = 1'b0; los_i = 1'b0; tick(3);
    rx_lol_i = 1'b1; tick(3); rx_lol_i = 1'b0;
    tick(10);
    chk(flags_o == 3'b100, "R8 no flags in power-down", flags_o, 4);

    // release: second reset
    pdrst_i = 1'b0; tick(5);
    chk(flags_o == 0 && int_no == 1, "R10 reset clears flags", flags_o, 0);
    tick(55);
    chk(int_no == 1, "R3 no early interrupt", int_no, 1);
    tick(15);
    chk(flags_o == 3'b001 && int_no == 0, "R2 reset after long pd", flags_o, 1);
    read_flags();

    // short glitch: no reset
    pdrst_i = 1'b1; tick(3); pdrst_i = 1'b0;
    tick(INIT + 10);
    chk(flags_o == 0 && int_no == 1, "R2 glitch ignored", flags_o, 0);
    chk(not_ready_o == 0 && lowpwr_o == 0, "R2 live after glitch", not_ready_o, 0);

    // power-on with pin high
    rst_ni = 1'b0; pdrst_i = 1'b1; tick(3); rst_ni = 1'b1;
    tick(INIT + 10);
    chk(lowpwr_o == 1, "R11 comes up low-power", lowpwr_o, 1);
    chk(flags_o == 3'b001 && int_no == 0, "R11 first completion", flags_o, 1);
    chk(not_ready_o == 1, "R5 forced in pd", not_ready_o, 1);
    read_flags();
    chk(int_no == 1, "R9 cleared in pd", int_no, 1);
    pdrst_i = 1'b0; tick(INIT + 10);
    chk(flags_o == 3'b001 && int_no == 0, "R11 second completion", flags_o, 1);
    chk(lowpwr_o == 0, "R11 normal mode", lowpwr_o, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule